// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave side of a small serial memory reached over SPI in mode 0. It keeps 256 bytes in a register array and samples the serial clock, chip select, serial input and pause inputs in the system clock domain. It decodes 8-bit commands for setting and clearing a write-enable latch, reading and writing a status byte, reading the array sequentially and writing up to one 16-byte page per frame. The serial output comes with a separate enable that the pad logic uses as a tristate control.

Writes are gathered in a page buffer. They reach the array only when chip select rises after a whole number of data bytes. A busy period of programmable length then follows, and during it only the status byte can be read. A pause input freezes a transfer without losing its bit position. Unknown commands are dropped silently. The write-enable latch clears after every write that completes.

Top module: `spimem_slave`

## Requirements
- R1: After reset the output enable is low, every array byte reads 0xFF and the status byte reads 0x00. The status byte holds busy in bit 0, the write-enable latch in bit 1 and two stored protect bits in bits 3:2; bits 7:4 read zero.
- R2: If chip select is low when reset is released, no command is taken in that frame. Commands are accepted only after chip select has been seen high and then low again.
- R3: Command 0x06 sets the write-enable latch and command 0x04 clears it. Command 0x05 returns the status byte, repeated for as long as the host keeps clocking.
- R4: Command 0x02 (write) and command 0x01 (status write) have no effect while the write-enable latch is clear.
- R5: A write frame is 0x02, one address byte, then data bytes. The data lands at successive addresses that wrap inside the 16-byte page of the start address, and a later byte overwrites an earlier one at the same offset. When chip select rises the write commits, the latch clears and busy is set.
- R6: If chip select rises partway through a byte, the whole write is dropped and the write-enable latch is left unchanged.
- R7: While busy, every command except 0x05 is ignored, the output enable stays low for it, and busy clears after BUSY_CYCLES system clocks.
- R8: Command 0x03 followed by an address byte returns bytes from successive addresses, wrapping from 0xFF to 0x00.
- R9: A pause starts when the pause input falls while SCK is low and ends when it rises while SCK is low. During a pause the output enable is low and SCK and SI are ignored; the transfer then resumes at the same bit.
- R10: If chip select rises during a pause, a pending write is aborted.
- R11: An unknown command keeps the output enable low for the rest of its frame and changes no state.
- R12: Command 0x01 with one data byte stores bits 3:2 of that byte as the protect bits, clears the latch and starts a busy period.
- R13: SI is sampled on the SCK rising edge. SO changes after the SCK falling edge, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset (stands in for power-on reset) |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| holdN | input | 1 | Active-low pause request |
| so | output | 1 | Serial data to the host |
| soEn | output | 1 | Drive enable for so; low means high impedance |

## Verification
Every page is written with a different start offset and a different arithmetic pattern, and some pages get more than 16 bytes. A single read of all 256 bytes and past the end then separates correct page wrapping, correct overwriting and a read address that wraps from one that does not. The write-enable rules are told apart with a write attempted with the latch clear, a write cancelled mid-byte, a write aborted under a pause, and a status write, each followed by a status read and an array read. A pause placed in the middle of a read byte shows whether bits are lost or duplicated. Commands sent during busy, an unknown opcode, and a frame left open across reset confirm that nothing is decoded when it should not be.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam logic [7:0] CmdWren  = 8'h06;
  localparam logic [7:0] CmdWrdi  = 8'h04;
  localparam logic [7:0] CmdRdsr  = 8'h05;
  localparam logic [7:0] CmdWrsr  = 8'h01;
  localparam logic [7:0] CmdRead  = 8'h03;
  localparam logic [7:0] CmdWrite = 8'h02;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_DATA, PH_DEAD
  } phase_t;

  typedef enum logic [1:0] {
    OP_READ, OP_WRITE, OP_RDSR, OP_WRSR
  } op_t;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadAddr;
    logic loadTxMem;
    logic loadTxStat;
    logic bufWrite;
    logic clearBuf;
    logic commitArray;
    logic commitStatus;
  } strobe_t;

endpackage

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckIn,
  input  logic       csNIn,
  input  logic       siIn,
  input  logic       holdNIn,
  input  logic [7:0] rxNext,
  output strobe_t    strb,
  output logic       siS,
  output logic       soEnable,
  output logic       wel,
  output logic       busy
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sckSh, csSh, siSh, holdSh;
  logic sckPrev, csPrev, holdPrev;
  logic sckS, csS, holdS;
  logic sckRise, sckFall, csRise, csFall, holdRise, holdFall;

  phase_t phase, phaseN;
  op_t op, opN;
  logic [2:0] bitCnt, bitN;
  logic holdOn, holdOnN, armed, armedN, welN, gotData, gotN;
  logic [BUSY_W-1:0] busyCnt, busyN;

  // input synchronizers; chip select starts low so a frame open at reset stays unarmed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh <= '0; csSh <= '0; siSh <= '0; holdSh <= '1;
      sckPrev <= 1'b0; csPrev <= 1'b0; holdPrev <= 1'b1;
    end else begin
      sckSh  <= {sckSh[TOP-1:0], sckIn};
      csSh   <= {csSh[TOP-1:0], csNIn};
      siSh   <= {siSh[TOP-1:0], siIn};
      holdSh <= {holdSh[TOP-1:0], holdNIn};
      sckPrev <= sckS; csPrev <= csS; holdPrev <= holdS;
    end
  end

  assign sckS  = sckSh[TOP];
  assign csS   = csSh[TOP];
  assign siS   = siSh[TOP];
  assign holdS = holdSh[TOP];
  assign sckRise  = sckS & ~sckPrev;
  assign sckFall  = ~sckS & sckPrev;
  assign csRise   = csS & ~csPrev;
  assign csFall   = ~csS & csPrev;
  assign holdRise = holdS & ~holdPrev;
  assign holdFall = ~holdS & holdPrev;
  assign busy = (busyCnt != '0);

  always_comb begin
    strb = '0;
    phaseN = phase; opN = op; bitN = bitCnt; holdOnN = holdOn;
    armedN = armed | csS; welN = wel; gotN = gotData;
    busyN = busy ? busyCnt - 1'b1 : busyCnt;
    if (csRise) begin
      if (phase == PH_DATA && gotData && bitCnt == 3'd0 && !holdOn &&
          (op == OP_WRITE || op == OP_WRSR)) begin
        strb.commitArray  = (op == OP_WRITE);
        strb.commitStatus = (op == OP_WRSR);
        welN  = 1'b0;
        busyN = BUSY_W'(BUSY_CYCLES);
      end
      phaseN = PH_IDLE;
      holdOnN = 1'b0;
    end else if (csFall && armed) begin
      phaseN = PH_OPC; bitN = '0; holdOnN = 1'b0; gotN = 1'b0;
      strb.clearBuf = 1'b1;
    end else if (phase != PH_IDLE && !csS) begin
      if (!holdOn && holdFall && !sckS) holdOnN = 1'b1;
      else if (holdOn && holdRise && !sckS) holdOnN = 1'b0;
      if (!holdOn && sckFall) strb.shiftOut = 1'b1;
      if (!holdOn && sckRise) begin
        strb.shiftIn = 1'b1;
        bitN = bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          unique case (phase)
            PH_OPC: begin
              phaseN = PH_DEAD;
              if (!busy || rxNext == CmdRdsr) begin
                case (rxNext)
                  CmdWren: welN = 1'b1;
                  CmdWrdi: welN = 1'b0;
                  CmdRdsr: begin phaseN = PH_DATA; opN = OP_RDSR; strb.loadTxStat = 1'b1; end
                  CmdWrsr: if (wel) begin phaseN = PH_DATA; opN = OP_WRSR; end
                  CmdRead: begin phaseN = PH_ADDR; opN = OP_READ; end
                  CmdWrite: if (wel) begin phaseN = PH_ADDR; opN = OP_WRITE; end
                  default: phaseN = PH_DEAD;
                endcase
              end
            end
            PH_ADDR: begin
              strb.loadAddr = 1'b1;
              strb.loadTxMem = (op == OP_READ);
              phaseN = PH_DATA;
            end
            PH_DATA: begin
              strb.loadTxMem  = (op == OP_READ);
              strb.loadTxStat = (op == OP_RDSR);
              if (op == OP_WRITE || op == OP_WRSR) begin
                strb.bufWrite = 1'b1;
                gotN = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; op <= OP_READ; bitCnt <= '0; holdOn <= 1'b0;
      armed <= 1'b0; wel <= 1'b0; gotData <= 1'b0; busyCnt <= '0;
    end else begin
      phase <= phaseN; op <= opN; bitCnt <= bitN; holdOn <= holdOnN;
      armed <= armedN; wel <= welN; gotData <= gotN; busyCnt <= busyN;
    end
  end

  assign soEnable = (phase == PH_DATA) && (op == OP_READ || op == OP_RDSR) && !holdOn;

  // R4
  commit_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitArray || strb.commitStatus) |-> wel);
  // R5
  commit_clears_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitArray || strb.commitStatus) |=> (!wel && busy));
  // R7
  no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.commitArray || strb.commitStatus));
  // R9
  hold_sck_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdOn) |-> !$past(sckS));

endmodule

// File: rtl/spimem_dp.sv
module spimem_dp
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic       siS,
  input  logic       wel,
  input  logic       busy,
  output logic [7:0] rxNext,
  output logic       soBit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] pageBuf [PAGE];
  logic [PAGE-1:0] mask;
  logic [7:0] rxSh, txSh, status;
  logic [ADDR_W-1:0] addr, addrSel;
  logic [1:0] bp, bpPend;

  assign rxNext  = {rxSh[6:0], siS};
  assign status  = {4'b0, bp, wel, busy};
  assign addrSel = strb.loadAddr ? rxNext[ADDR_W-1:0] : addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE; i++) pageBuf[i] <= '0;
      mask <= '0; rxSh <= '0; txSh <= '0; soBit <= 1'b0;
      addr <= '0; bp <= '0; bpPend <= '0;
    end else begin
      if (strb.shiftIn) rxSh <= rxNext;
      if (strb.loadTxMem) begin
        txSh <= mem[addrSel];
        addr <= addrSel + 1'b1;
      end else if (strb.loadAddr) begin
        addr <= addrSel;
      end
      if (strb.loadTxStat) txSh <= status;
      if (strb.shiftOut) begin
        soBit <= txSh[7];
        txSh  <= {txSh[6:0], 1'b0};
      end
      if (strb.bufWrite) begin
        pageBuf[addr[PAGE_W-1:0]] <= rxNext;
        mask[addr[PAGE_W-1:0]] <= 1'b1;
        bpPend <= rxNext[3:2];
        addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
      end
      if (strb.clearBuf) mask <= '0;
      if (strb.commitArray) begin
        for (int i = 0; i < PAGE; i++)
          if (mask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
        mask <= '0;
      end
      if (strb.commitStatus) bp <= bpPend;
    end
  end

  // R5
  commit_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitArray |-> (mask != '0));

endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
  import spimem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 600
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic si,
  input  logic holdN,
  output logic so,
  output logic soEn
);
  strobe_t strb;
  logic siS, wel, busy;
  logic [7:0] rxNext;

  spimem_ctrl #(.SYNC_STAGES(SYNC_STAGES), .BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .siIn(si), .holdNIn(holdN),
    .rxNext(rxNext), .strb(strb), .siS(siS), .soEnable(soEn), .wel(wel), .busy(busy)
  );

  spimem_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .siS(siS), .wel(wel), .busy(busy),
    .rxNext(rxNext), .soBit(so)
  );

endmodule

// File: tb/tb_spimem_slave.sv
module tb_spimem_slave;
  localparam int H = 6;
  localparam int BUSY = 600;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, csN = 1'b0, si = 1'b0, holdN = 1'b1;
  logic so, soEn;
  int checks = 0, errors = 0;
  logic [7:0] model [256];

  spimem_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .holdN(holdN),
    .so(so), .soEn(soEn)
  );

  always #2 clk = ~clk;

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input int holdAt,
                      output logic [7:0] rx, output int oeCnt);
    rx = '0; oeCnt = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sck = 1'b0; si = tx[i];
      waitClk(H);
      if (i == holdAt) begin
        holdN = 1'b0;
        waitClk(H);
        chk("R9 soEn during pause", int'(soEn), 0);
        for (int w = 0; w < 3; w++) begin
          sck = 1'b1; si = ~si; waitClk(H);
          sck = 1'b0; waitClk(H);
        end
        si = tx[i];
        holdN = 1'b1;
        waitClk(H);
      end
      sck = 1'b1;
      waitClk(H);
      rx[i] = so;
      oeCnt += int'(soEn);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; int o;
    xfer(tx, 8, -1, r, o);
  endtask

  task automatic csLow;
    sck = 1'b0; csN = 1'b0; waitClk(H);
  endtask

  task automatic csHigh;
    sck = 1'b0; waitClk(H); csN = 1'b1; waitClk(2 * H);
  endtask

  task automatic rdsr(output logic [7:0] st, output int oe);
    csLow; send(8'h05); xfer(8'h00, 8, -1, st, oe); csHigh;
  endtask

  task automatic expectStatus(input string req, input int exp);
    logic [7:0] st; int oe;
    rdsr(st, oe);
    chk({req, " status"}, int'(st), exp);
    chk({req, " status soEn"}, oe, 8);
  endtask

  task automatic waitReady(input string req);
    logic [7:0] st; int oe; int n;
    n = 0;
    do begin rdsr(st, oe); n++; end while (st[0] && n < 12);
    chk({req, " busy clears"}, int'(st[0]), 0);
  endtask

  task automatic cmd1(input logic [7:0] c);
    csLow; send(c); csHigh;
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 37 + k * 11 + 5) ^ (k << 4));
  endfunction

  // write n bytes at a, pattern seed s; updates model when commit expected
  task automatic writeBytes(input int a, input int n, input int s, input bit upd);
    csLow; send(8'h02); send(8'(a));
    for (int k = 0; k < n; k++) begin
      send(pat(s, k));
      if (upd) model[(a & 8'hF0) | ((a + k) & 8'h0F)] = pat(s, k);
    end
    csHigh;
  endtask

  task automatic readSeq(input string req, input int a, input int n);
    logic [7:0] r; int oe;
    csLow; send(8'h03); send(8'(a));
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, -1, r, oe);
      chk(req, int'(r), int'(model[(a + k) % 256]));
      if (k == 0) chk({req, " soEn"}, oe, 8);
    end
    csHigh;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary;
  end

  initial begin
    logic [7:0] r, r2; int oe, oe2;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    chk("R1 soEn after reset", int'(soEn), 0);
    // R2: frame already open at reset
    send(8'h05);
    xfer(8'h00, 8, -1, r, oe);
    chk("R2 no decode in open frame", oe, 0);
    csHigh;
    // R1 / R13
    expectStatus("R1 R13", 8'h00);
    readSeq("R1 erased", 0, 16);
    // R4
    writeBytes(8'h10, 1, 1, 1'b0);
    expectStatus("R4", 8'h00);
    readSeq("R4 unchanged", 8'h10, 1);
    // R3
    cmd1(8'h06); expectStatus("R3 wren", 8'h02);
    cmd1(8'h04); expectStatus("R3 wrdi", 8'h00);
    cmd1(8'h06);
    // R11
    csLow; send(8'hA5);
    xfer(8'h00, 8, -1, r, oe); xfer(8'h00, 8, -1, r, oe2);
    csHigh;
    chk("R11 soEn", oe + oe2, 0);
    expectStatus("R11 state kept", 8'h02);
    // R5 wrap within page, R7 busy behaviour
    writeBytes(8'h2E, 4, 2, 1'b1);
    cmd1(8'h06);
    expectStatus("R5 R7", 8'h01);
    csLow; send(8'h03); send(8'h2E); xfer(8'h00, 8, -1, r, oe); csHigh;
    chk("R7 read ignored while busy", oe, 0);
    waitReady("R7");
    expectStatus("R7 wren ignored", 8'h00);
    readSeq("R5 page wrap", 8'h20, 16);
    // sweep every page, offsets and lengths vary, some longer than a page
    for (int p = 0; p < 16; p++) begin
      cmd1(8'h06);
      writeBytes(p * 16 + p, 16 + (p % 3), 100 + p, 1'b1);
      waitReady("R5 sweep");
    end
    readSeq("R8 R5 full read", 0, 260);
    // R6 mid-byte cancel
    cmd1(8'h06);
    csLow; send(8'h02); send(8'h50); send(8'h11);
    xfer(8'h22, 3, -1, r, oe);
    csHigh;
    expectStatus("R6", 8'h02);
    readSeq("R6 unchanged", 8'h50, 2);
    // R9 pause in the middle of read bytes
    csLow; send(8'h03); send(8'h40);
    xfer(8'h00, 8, 4, r, oe);
    xfer(8'h00, 8, 6, r2, oe2);
    csHigh;
    chk("R9 byte0", int'(r), int'(model[8'h40]));
    chk("R9 byte1", int'(r2), int'(model[8'h41]));
    // R10 abort on chip-select rise during pause
    csLow; send(8'h02); send(8'h60); send(8'h5A);
    sck = 1'b0; waitClk(H); holdN = 1'b0; waitClk(H);
    csN = 1'b1; waitClk(H); holdN = 1'b1; waitClk(2 * H);
    expectStatus("R10", 8'h02);
    readSeq("R10 unchanged", 8'h60, 1);
    // R12
    csLow; send(8'h01); send(8'hFF); csHigh;
    expectStatus("R12 busy", 8'h0D);
    waitReady("R12");
    expectStatus("R12 stored", 8'h0C);
    csLow; send(8'h01); send(8'h00); csHigh;
    expectStatus("R12 R4 no wel", 8'h0C);
    summary;
  end

endmodule